// File: doc/BRIEF.md
# Pedal Bass Note Selector Latch

This block turns a bank of pedal keys into a single sustained bass note selection. The keys are split into groups of equal size, and each group feeds its own priority encoder. The encoders are chained so that any active key in a higher group silences every lower group. The winning encoder supplies a note code that says which key in its group won. The chain also yields a group code that says which group won.

On each clock edge where the keydown strobe is high and at least one key is pressed, a bank of registered latches captures the note code and the group code. The latched codes then stay put after the pedal is released, so the note keeps sounding.

There is one 1-of-N tone selector per group, and all of them receive the same latched note code. Only the selector named by the latched group code is enabled. The output is the tone line that this enabled selector picks. After reset no selector is enabled and the output is silent.

Top module: `pedal_note_latch`

## Requirements
- R1: While and directly after an active-low synchronous reset, `grp_valid_o` is 0, `note_code_o` and `grp_code_o` are 0, and `tone_o` is 0 whatever `tone_i` holds.
- R2: With exactly one key k pressed and `keydown_i` high at a rising edge, the outputs after that edge are: `grp_valid_o`=1, `grp_code_o`=k / keys-per-group, and `note_code_o`=k mod keys-per-group. Key index k is the bit position in `key_i`.
- R3: Within one group, the highest-numbered pressed key wins. The top input of a group gives note code all ones (7 for groups of eight).
- R4: When keys in several groups are pressed at once, the highest-numbered group wins and all lower groups are ignored. The selected key is therefore the most significant set bit of `key_i`.
- R5: Once latched, the note code, group code and valid flag keep their values after every key is released and `keydown_i` falls.
- R6: While `keydown_i` is low, changes on `key_i` have no effect on the latched outputs.
- R7: A rising edge with `keydown_i` high but no key pressed leaves the latched outputs unchanged.
- R8: When `grp_valid_o` is 1, `tone_o` equals `tone_i[grp_code_o*keys-per-group + note_code_o]`.
- R9: At most one tone selector is enabled at any time. None is enabled while `grp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_i | input | NUM_GROUPS*KEYS_PER_GROUP (24) | Pedal key requests, active high, bit k = key k |
| keydown_i | input | 1 | Keydown strobe that allows the latches to update |
| tone_i | input | NUM_GROUPS*KEYS_PER_GROUP (24) | Tone lines, one per key |
| note_code_o | output | CODE_W (3) | Latched note code within the group |
| grp_code_o | output | GRP_W (2) | Latched group index |
| grp_valid_o | output | 1 | A note has been latched since reset |
| tone_o | output | 1 | Tone line of the enabled selector |

## Verification
The bench uses the default build: three groups of eight keys. With this build, every key index from 0 to 23 can be pressed on its own. The middle group is the interesting case, because it is suppressed from above and also suppresses the group below. The build also gives the full 3-bit note code, and it leaves group code 3 unused so that it never enables a selector. Random multi-key patterns across all three groups test the cascade priority. Random tone patterns show that only the addressed line reaches the output.

// File: rtl/pedal_note_pkg.sv
// Package: shared defaults and a width helper for the pedal note selector.
// Assumes: used by every module of the block; holds no state.
package pedal_note_pkg;
    localparam int unsigned DEF_KEYS_PER_GROUP = 8;
    localparam int unsigned DEF_NUM_GROUPS     = 3;

    // Bit width needed to index n items, never below one.
    function automatic int unsigned idx_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction
endpackage

// File: rtl/pedal_prio_enc.sv
// Module: one priority encoder stage of the key cascade.
// Function: reports the highest active request as a binary code.
// It asserts a group-select flag when enabled and any request is
// active, and it passes its enable on to the next lower stage only
// while it has no requests.
// Assumes: N is a power of two; requests are active high.
module pedal_prio_enc #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 3
) (
    input  logic [N-1:0] req_i,
    input  logic         en_i,
    output logic [W-1:0] code_o,
    output logic         gs_o,
    output logic         en_o
);
    logic any_req;

    // Purpose: detect any active request.
    always_comb any_req = |req_i;

    // Purpose: scan upward so the highest request index sets the code.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (req_i[i]) code_o = W'(i);
        end
        if (!en_i) code_o = '0;
    end

    // Purpose: group-select flag and the enable handed down the cascade.
    always_comb begin
        gs_o = en_i & any_req;
        en_o = en_i & ~any_req;
    end
endmodule

// File: rtl/pedal_enc_cascade.sv
// Module: chain of priority encoders, one per key group.
// Function: the highest group owns the chain and each group enables the
// one below only when it is idle. Produces the winning note code, the
// winning group index and a flag that some key is pressed.
// Assumes: at most one stage asserts its group-select flag at a time.
module pedal_enc_cascade #(
    parameter int unsigned KEYS_PER_GROUP = 8,
    parameter int unsigned NUM_GROUPS     = 3,
    parameter int unsigned CODE_W         = 3,
    parameter int unsigned GRP_W          = 2
) (
    input  logic [NUM_GROUPS*KEYS_PER_GROUP-1:0] key_i,
    output logic [CODE_W-1:0]                    code_o,
    output logic [GRP_W-1:0]                     grp_o,
    output logic                                 any_o
);
    logic [NUM_GROUPS:0]      chain_en;
    logic [NUM_GROUPS-1:0]    gs;
    logic [CODE_W-1:0]        stage_code [NUM_GROUPS];

    // Purpose: the top of the chain is always enabled.
    always_comb chain_en[NUM_GROUPS] = 1'b1;

    for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_stage
        pedal_prio_enc #(
            .N (KEYS_PER_GROUP),
            .W (CODE_W)
        ) u_enc (
            .req_i  (key_i[g*KEYS_PER_GROUP +: KEYS_PER_GROUP]),
            .en_i   (chain_en[g+1]),
            .code_o (stage_code[g]),
            .gs_o   (gs[g]),
            .en_o   (chain_en[g])
        );
    end

    // Purpose: merge the stage codes and encode the winning group index.
    always_comb begin
        code_o = '0;
        grp_o  = '0;
        for (int g = 0; g < int'(NUM_GROUPS); g++) begin
            code_o = code_o | stage_code[g];
            if (gs[g]) grp_o = GRP_W'(g);
        end
        any_o = |gs;
    end
endmodule

// File: rtl/pedal_code_latch.sv
// Module: registered hold latches for the note code and the group code.
// Function: each note bit has its own set/reset pair, gated by the
// update strobe; the group code and valid flag load on the same strobe.
// Assumes: synchronous active-low reset clears everything.
module pedal_code_latch #(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [GRP_W-1:0]  grp_i,
    output logic [CODE_W-1:0] code_q,
    output logic [GRP_W-1:0]  grp_q,
    output logic              valid_q
);
    for (genvar b = 0; b < int'(CODE_W); b++) begin : g_bit
        logic set_b;
        logic clr_b;

        // Purpose: derive set and reset requests for this bit.
        always_comb begin
            set_b = upd_i & code_i[b];
            clr_b = upd_i & ~code_i[b];
        end

        // Purpose: hold the bit, changing only on a set or reset.
        always_ff @(posedge clk) begin
            if (!rst_n)     code_q[b] <= 1'b0;
            else if (set_b) code_q[b] <= 1'b1;
            else if (clr_b) code_q[b] <= 1'b0;
        end
    end

    // Purpose: hold the group code and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            valid_q <= 1'b0;
        end else if (upd_i) begin
            grp_q   <= grp_i;
            valid_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pedal_tone_sel.sv
// Module: bank of per-group tone selectors sharing one note code.
// Function: decodes the group code into selector enables, and each
// enabled selector picks one tone line of its group; outputs are ORed.
// Assumes: group codes at or above NUM_GROUPS enable nothing.
module pedal_tone_sel #(
    parameter int unsigned KEYS_PER_GROUP = 8,
    parameter int unsigned NUM_GROUPS     = 3,
    parameter int unsigned CODE_W         = 3,
    parameter int unsigned GRP_W          = 2
) (
    input  logic [NUM_GROUPS*KEYS_PER_GROUP-1:0] tone_i,
    input  logic [CODE_W-1:0]                    code_i,
    input  logic [GRP_W-1:0]                     grp_i,
    input  logic                                 valid_i,
    output logic [NUM_GROUPS-1:0]                sel_en_o,
    output logic                                 tone_o
);
    logic [NUM_GROUPS-1:0] sel_out;

    for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_sel
        logic [KEYS_PER_GROUP-1:0] lines;

        // Purpose: enable this selector and pick its addressed line.
        always_comb begin
            lines       = tone_i[g*KEYS_PER_GROUP +: KEYS_PER_GROUP];
            sel_en_o[g] = valid_i && (grp_i == GRP_W'(g));
            sel_out[g]  = sel_en_o[g] & lines[code_i];
        end
    end

    // Purpose: combine selector outputs onto the single tone line.
    always_comb tone_o = |sel_out;
endmodule

// File: rtl/pedal_note_latch.sv
// Module: top of the pedal bass note selector latch.
// Function: the key cascade picks a note, the latches hold it while
// keydown is absent, and the selector bank routes the held note's tone.
// Assumes: keys and keydown are synchronous to clk.
module pedal_note_latch
    import pedal_note_pkg::*;
#(
    parameter int unsigned KEYS_PER_GROUP = DEF_KEYS_PER_GROUP,
    parameter int unsigned NUM_GROUPS     = DEF_NUM_GROUPS,
    localparam int unsigned NUM_KEYS      = KEYS_PER_GROUP * NUM_GROUPS,
    localparam int unsigned CODE_W        = idx_width(KEYS_PER_GROUP),
    localparam int unsigned GRP_W         = idx_width(NUM_GROUPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_i,
    input  logic                keydown_i,
    input  logic [NUM_KEYS-1:0] tone_i,
    output logic [CODE_W-1:0]   note_code_o,
    output logic [GRP_W-1:0]    grp_code_o,
    output logic                grp_valid_o,
    output logic                tone_o
);
    logic [CODE_W-1:0]     enc_code;
    logic [GRP_W-1:0]      enc_grp;
    logic                  enc_any;
    logic                  upd;
    logic [NUM_GROUPS-1:0] sel_en;

    pedal_enc_cascade #(
        .KEYS_PER_GROUP (KEYS_PER_GROUP),
        .NUM_GROUPS     (NUM_GROUPS),
        .CODE_W         (CODE_W),
        .GRP_W          (GRP_W)
    ) u_cascade (
        .key_i  (key_i),
        .code_o (enc_code),
        .grp_o  (enc_grp),
        .any_o  (enc_any)
    );

    // Purpose: latches load only on keydown with a key actually pressed.
    always_comb upd = keydown_i & enc_any;

    pedal_code_latch #(
        .CODE_W (CODE_W),
        .GRP_W  (GRP_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .code_i  (enc_code),
        .grp_i   (enc_grp),
        .code_q  (note_code_o),
        .grp_q   (grp_code_o),
        .valid_q (grp_valid_o)
    );

    pedal_tone_sel #(
        .KEYS_PER_GROUP (KEYS_PER_GROUP),
        .NUM_GROUPS     (NUM_GROUPS),
        .CODE_W         (CODE_W),
        .GRP_W          (GRP_W)
    ) u_sel (
        .tone_i   (tone_i),
        .code_i   (note_code_o),
        .grp_i    (grp_code_o),
        .valid_i  (grp_valid_o),
        .sel_en_o (sel_en),
        .tone_o   (tone_o)
    );
endmodule

// File: rtl/pedal_note_latch_chk.sv
// Module: property checker for the pedal note selector latch.
// Function: watches ports and the selector enables over time.
// Assumes: bound to every instance of pedal_note_latch.
module pedal_note_latch_chk #(
    parameter int unsigned NUM_KEYS   = 24,
    parameter int unsigned NUM_GROUPS = 3,
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned GRP_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_KEYS-1:0]   key_i,
    input logic                  keydown_i,
    input logic [CODE_W-1:0]     note_code_o,
    input logic [GRP_W-1:0]      grp_code_o,
    input logic                  grp_valid_o,
    input logic                  tone_o,
    input logic [NUM_GROUPS-1:0] sel_en
);
    // R1: state left by reset is cleared when reset lifts.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!grp_valid_o && note_code_o == '0 && grp_code_o == '0));

    // R2: a pressed key with keydown makes the latched note valid.
    a_r2_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (keydown_i && (|key_i)) |=> grp_valid_o);

    // R5/R6: without keydown the latched codes hold.
    a_r6_hold_no_keydown: assert property (@(posedge clk) disable iff (!rst_n)
        !keydown_i |=> ($stable(note_code_o) && $stable(grp_code_o) && $stable(grp_valid_o)));

    // R7: keydown with no key leaves the latched codes alone.
    a_r7_hold_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        (keydown_i && !(|key_i)) |=> ($stable(note_code_o) && $stable(grp_code_o) && $stable(grp_valid_o)));

    // R8: no latched note means a silent output.
    a_r8_silent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid_o |-> !tone_o);

    // R9: at most one selector enabled, none before a note is latched.
    a_r9_one_selector: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_en) && (grp_valid_o || sel_en == '0));
endmodule

bind pedal_note_latch pedal_note_latch_chk #(
    .NUM_KEYS   (NUM_KEYS),
    .NUM_GROUPS (NUM_GROUPS),
    .CODE_W     (CODE_W),
    .GRP_W      (GRP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_i       (key_i),
    .keydown_i   (keydown_i),
    .note_code_o (note_code_o),
    .grp_code_o  (grp_code_o),
    .grp_valid_o (grp_valid_o),
    .tone_o      (tone_o),
    .sel_en      (sel_en)
);

// File: tb/pedal_note_latch_bench.sv
// Bench: directed and seeded random stimulus for pedal_note_latch,
// compared against a reference state held in the bench.
module pedal_note_latch_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  KPG        = 8;
    localparam int  NG         = 3;
    localparam int  NK         = KPG * NG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NK-1:0] key_i = '0;
    logic          keydown_i = 1'b0;
    logic [NK-1:0] tone_i = '0;
    logic [2:0]    note_code_o;
    logic [1:0]    grp_code_o;
    logic          grp_valid_o;
    logic          tone_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference state.
    int exp_idx   = 0;
    bit exp_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pedal_note_latch u_pedal_note_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_i       (key_i),
        .keydown_i   (keydown_i),
        .tone_i      (tone_i),
        .note_code_o (note_code_o),
        .grp_code_o  (grp_code_o),
        .grp_valid_o (grp_valid_o),
        .tone_o      (tone_o)
    );

    // Index of the most significant pressed key, -1 when none.
    function automatic int top_key(input logic [NK-1:0] k);
        int r = -1;
        for (int i = 0; i < NK; i++) if (k[i]) r = i;
        return r;
    endfunction

    // Reference update for one clock edge.
    task automatic model_edge();
        int t = top_key(key_i);
        if (keydown_i && t >= 0) begin
            exp_idx   = t;
            exp_valid = 1'b1;
        end
    endtask

    // Apply current inputs across one edge, then sample at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic check(input string req);
        logic exp_tone;
        int   act_idx;
        exp_tone = exp_valid ? tone_i[exp_idx] : 1'b0;
        act_idx  = int'(grp_code_o) * KPG + int'(note_code_o);
        checks++;
        if (grp_valid_o !== exp_valid || tone_o !== exp_tone ||
            (exp_valid && act_idx != exp_idx) ||
            (!exp_valid && act_idx != 0)) begin
            errors++;
            $display("FAIL %s: valid=%0b idx=%0d tone=%0b expected valid=%0b idx=%0d tone=%0b",
                     req, grp_valid_o, act_idx, tone_o, exp_valid,
                     exp_valid ? exp_idx : 0, exp_tone);
        end
    endtask

    initial begin
        void'($urandom(32'd5150));
        tone_i = '1;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R2, R5, R8: each key alone, then released.
        for (int k = 0; k < NK; k++) begin
            tone_i    = NK'($urandom());
            key_i     = '0;
            key_i[k]  = 1'b1;
            keydown_i = 1'b1;
            step();
            check("R2 single key held");
            tone_i[exp_idx] = ~tone_i[exp_idx];
            #1 check("R8 tone follows line");
            key_i     = '0;
            keydown_i = 1'b0;
            step();
            check("R5 sustain after release");
        end

        // R3: two keys in one group, top input wins.
        key_i = '0; key_i[3] = 1'b1; key_i[7] = 1'b1; keydown_i = 1'b1;
        step();
        check("R3 in-group priority");
        // R4: keys in three groups, top group wins.
        key_i = '0; key_i[5] = 1'b1; key_i[12] = 1'b1; key_i[20] = 1'b1;
        step();
        check("R4 cross-group priority");
        key_i = '0; key_i[15] = 1'b1; key_i[1] = 1'b1;
        step();
        check("R4 middle group beats bottom");
        // R6: keys move with keydown low.
        keydown_i = 1'b0; key_i = '0; key_i[22] = 1'b1;
        step();
        check("R6 keydown low ignores keys");
        // R7: keydown with nothing pressed.
        keydown_i = 1'b1; key_i = '0;
        step();
        check("R7 keydown without key");

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            key_i = NK'($urandom()) & NK'($urandom()) & NK'($urandom());
            keydown_i = 1'($urandom());
            tone_i = NK'($urandom());
            step();
            check("R4 random pattern");
        end

        // R1 again: reset in the middle of a held note.
        rst_n = 1'b0;
        step();
        exp_valid = 1'b0; exp_idx = 0;
        check("R1 reset while held");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule